// File: doc/BRIEF.md
# R-format Execution Unit

This block executes register-to-register integer instructions, one per clock cycle. Each cycle it may take a 32-bit instruction word with a valid strobe. It splits the word into its fixed fields and reads two source registers from an internal 32 x 32-bit register file. It then adds or subtracts them, as the function field selects, and writes the result into the destination register on the next rising edge. Register 0 is wired to zero.

Words that are not a supported register-format operation do not touch the register file. For such a word the block raises a single-cycle illegal flag. A debug port can read any register combinationally. The same port can also load a register, so a test environment can seed operand values. The instruction path has no immediate operand, so it cannot create nonzero values from a zeroed file.

Top module: `rfx_exec_unit`

## Requirements
- R1: The instruction word is decoded as opcode [31:26], first source [25:21], second source [20:16], destination [15:11], shift amount [10:6] and function [5:0]. Only opcode 0 selects this register format.
- R2: A valid word with opcode 0 and function 0x20 writes (src1 + src2) mod 2^32 to the destination register on the next rising edge.
- R3: A valid word with opcode 0 and function 0x22 writes (src1 - src2) mod 2^32 to the destination register, with the first source as minuend. No overflow indication is produced.
- R4: Register 0 reads as zero on every read port. Writes to it, from an instruction or from the debug port, are discarded.
- R5: A valid word with a nonzero opcode, or with a function other than 0x20 or 0x22, raises `illegal_o` in the cycle after the edge that sampled it. The flag lasts one cycle per such word, and no register changes.
- R6: While `instr_valid` is low, no register is written and `illegal_o` stays low in the following cycle, whatever `instr_word` holds.
- R7: A synchronous active-high reset clears every register and `illegal_o`.
- R8: Reads have no bypass. During a cycle, reads return the value stored before that cycle's write edge. An instruction in the next cycle sees the new value.
- R9: `dbg_rdata` combinationally returns the register selected by `dbg_addr`.
- R10: A high `dbg_we` writes `dbg_wdata` into register `dbg_addr` on the rising edge. When an instruction writes the same register in that cycle, the instruction result is stored. Writes to different registers both take effect.
- R11: The shift-amount field has no effect on add or subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction word |
| illegal_o | output | 1 | One-cycle flag for an unsupported valid word |
| dbg_addr | input | 5 | Debug register select (read and write) |
| dbg_we | input | 1 | Debug write enable |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Contents of the selected register |

## Verification
Two of the block's functions can act in the same cycle. An instruction result and a debug load can both target the file at one edge. A debug read can also observe a register while an instruction is about to overwrite it. The bench drives a debug load and an add to the same destination at one edge and expects the add result. It repeats this with distinct destinations and expects both values. It reads a register through the debug port just before the edge of a write to that register and expects the old contents, then reads it again after the edge and expects the new ones.

// File: rtl/rfx_pkg.sv
package rfx_pkg;

    localparam int INSN_W  = 32;
    localparam int OPC_W   = 6;
    localparam int REG_W   = 5;
    localparam int SHAMT_W = 5;
    localparam int FUNCT_W = 6;
    localparam int RF_DEPTH = 2 ** REG_W;

    localparam logic [OPC_W-1:0]   OPC_RTYPE = '0;
    localparam logic [FUNCT_W-1:0] FN_ADD    = 6'h20;
    localparam logic [FUNCT_W-1:0] FN_SUB    = 6'h22;

    typedef struct packed {
        logic [OPC_W-1:0]   opcode;
        logic [REG_W-1:0]   src1;
        logic [REG_W-1:0]   src2;
        logic [REG_W-1:0]   dst;
        logic [SHAMT_W-1:0] shamt;
        logic [FUNCT_W-1:0] funct;
    } rword_t;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_NONE = 2'd2
    } alu_op_e;

    function automatic alu_op_e classify(input rword_t w);
        if (w.opcode != OPC_RTYPE) return OP_NONE;
        case (w.funct)
            FN_ADD:  return OP_ADD;
            FN_SUB:  return OP_SUB;
            default: return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rfx_decode.sv
module rfx_decode
    import rfx_pkg::*;
(
    input  logic              valid_i,
    input  logic [INSN_W-1:0] word_i,
    output logic [REG_W-1:0]  src1_o,
    output logic [REG_W-1:0]  src2_o,
    output logic [REG_W-1:0]  dst_o,
    output alu_op_e           op_o,
    output logic              we_o,
    output logic              bad_o
);
    rword_t  fields;
    alu_op_e op;

    always_comb begin
        fields = rword_t'(word_i);
        op     = classify(fields);
        src1_o = fields.src1;
        src2_o = fields.src2;
        dst_o  = fields.dst;
        op_o   = op;
        we_o   = valid_i && (op != OP_NONE);
        bad_o  = valid_i && (op == OP_NONE);
    end
endmodule

// File: rtl/rfx_alu.sv
module rfx_alu
    import rfx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] y_o
);
    always_comb begin
        case (op_i)
            OP_ADD:  y_o = a_i + b_i;
            OP_SUB:  y_o = a_i - b_i;
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/rfx_regfile.sv
module rfx_regfile
    import rfx_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int DEPTH = RF_DEPTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   ra_a,
    output logic [XLEN-1:0] rd_a,
    input  logic [AW-1:0]   ra_b,
    output logic [XLEN-1:0] rd_b,
    input  logic [AW-1:0]   ra_d,
    output logic [XLEN-1:0] rd_d,
    input  logic            we_lo,
    input  logic [AW-1:0]   wa_lo,
    input  logic [XLEN-1:0] wd_lo,
    input  logic            we_hi,
    input  logic [AW-1:0]   wa_hi,
    input  logic [XLEN-1:0] wd_hi
);
    logic [XLEN-1:0] mem [DEPTH];

    // Two write sources; the later (hi) assignment takes priority on a clash.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (we_lo && (wa_lo != '0)) mem[wa_lo] <= wd_lo;
            if (we_hi && (wa_hi != '0)) mem[wa_hi] <= wd_hi;
        end
    end

    always_comb begin
        rd_a = (ra_a == '0) ? '0 : mem[ra_a];
        rd_b = (ra_b == '0) ? '0 : mem[ra_b];
        rd_d = (ra_d == '0) ? '0 : mem[ra_d];
    end
endmodule

// File: rtl/rfx_exec_unit.sv
module rfx_exec_unit
    import rfx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [INSN_W-1:0] instr_word,
    output logic              illegal_o,
    input  logic [REG_W-1:0]  dbg_addr,
    input  logic              dbg_we,
    input  logic [XLEN-1:0]   dbg_wdata,
    output logic [XLEN-1:0]   dbg_rdata
);
    logic [REG_W-1:0] src1, src2, dst;
    alu_op_e          op;
    logic             inst_we;
    logic             inst_bad;
    logic [XLEN-1:0]  opa, opb, result;

    rfx_decode u_dec (
        .valid_i (instr_valid),
        .word_i  (instr_word),
        .src1_o  (src1),
        .src2_o  (src2),
        .dst_o   (dst),
        .op_o    (op),
        .we_o    (inst_we),
        .bad_o   (inst_bad)
    );

    rfx_regfile #(.XLEN(XLEN), .DEPTH(RF_DEPTH)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .ra_a  (src1),
        .rd_a  (opa),
        .ra_b  (src2),
        .rd_b  (opb),
        .ra_d  (dbg_addr),
        .rd_d  (dbg_rdata),
        .we_lo (dbg_we),
        .wa_lo (dbg_addr),
        .wd_lo (dbg_wdata),
        .we_hi (inst_we),
        .wa_hi (dst),
        .wd_hi (result)
    );

    rfx_alu #(.XLEN(XLEN)) u_alu (
        .op_i (op),
        .a_i  (opa),
        .b_i  (opb),
        .y_o  (result)
    );

    always_ff @(posedge clk) begin
        if (rst) illegal_o <= 1'b0;
        else     illegal_o <= inst_bad;
    end
endmodule

// File: rtl/rfx_exec_checker.sv
module rfx_exec_checker (
    input logic        clk,
    input logic        rst,
    input logic        instr_valid,
    input logic [31:0] instr_word,
    input logic        illegal_o,
    input logic [4:0]  dbg_addr,
    input logic [31:0] dbg_rdata,
    input logic        inst_we
);
    // R5: the flag only follows a cycle that carried a valid word
    a_r5_flag_needs_valid: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> $past(instr_valid));

    // R5: a foreign opcode never produces a register write
    a_r5_bad_no_write: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && (instr_word[31:26] != 6'd0)) |-> !inst_we);

    // R4: register 0 reads zero through the debug port
    a_r4_zero_read: assert property (@(posedge clk) disable iff (rst)
        (dbg_addr == 5'd0) |-> (dbg_rdata == 32'd0));

    // R6: an idle cycle leaves the flag low afterwards
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> !illegal_o);

    // R6: an idle cycle writes nothing from the instruction path
    a_r6_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> !inst_we);
endmodule

bind rfx_exec_unit rfx_exec_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .illegal_o   (illegal_o),
    .dbg_addr    (dbg_addr),
    .dbg_rdata   (dbg_rdata),
    .inst_we     (inst_we)
);

// File: tb/test_rfx_exec_unit.sv
module test_rfx_exec_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        illegal_o;
    logic [4:0]  dbg_addr = '0;
    logic        dbg_we = 1'b0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    rfx_exec_unit i_rfx_exec_unit (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .illegal_o   (illegal_o),
        .dbg_addr    (dbg_addr),
        .dbg_we      (dbg_we),
        .dbg_wdata   (dbg_wdata),
        .dbg_rdata   (dbg_rdata)
    );

    function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] s1,
                                        input logic [4:0] s2, input logic [4:0] d,
                                        input logic [4:0] sh, input logic [5:0] fn);
        return {op, s1, s2, d, sh, fn};
    endfunction

    typedef struct packed {
        logic [31:0] word;
        logic [4:0]  chk;
        logic [31:0] exp;
        logic        ill;
    } vec_t;

    // seeds: r1=7 r2=5 r3=FFFFFFFF r4=80000000
    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{enc(6'h00, 5'd1, 5'd2, 5'd5,  5'd0,  6'h20), 5'd5,  32'h0000000C, 1'b0}, // R2
        '{enc(6'h00, 5'd1, 5'd2, 5'd6,  5'd0,  6'h22), 5'd6,  32'h00000002, 1'b0}, // R3
        '{enc(6'h00, 5'd2, 5'd1, 5'd7,  5'd0,  6'h22), 5'd7,  32'hFFFFFFFE, 1'b0}, // R3 order
        '{enc(6'h00, 5'd3, 5'd1, 5'd8,  5'd0,  6'h20), 5'd8,  32'h00000006, 1'b0}, // R2 wrap
        '{enc(6'h00, 5'd4, 5'd1, 5'd9,  5'd0,  6'h22), 5'd9,  32'h7FFFFFF9, 1'b0}, // R3 wrap
        '{enc(6'h00, 5'd1, 5'd2, 5'd0,  5'd0,  6'h20), 5'd0,  32'h00000000, 1'b0}, // R4
        '{enc(6'h00, 5'd0, 5'd1, 5'd10, 5'd0,  6'h20), 5'd10, 32'h00000007, 1'b0}, // R4 read
        '{enc(6'h00, 5'd5, 5'd5, 5'd5,  5'd0,  6'h20), 5'd5,  32'h00000018, 1'b0}, // R8
        '{enc(6'h00, 5'd5, 5'd6, 5'd11, 5'd0,  6'h22), 5'd11, 32'h00000016, 1'b0}, // R8 chain
        '{enc(6'h00, 5'd1, 5'd2, 5'd12, 5'd31, 6'h20), 5'd12, 32'h0000000C, 1'b0}, // R11
        '{enc(6'h08, 5'd1, 5'd2, 5'd1,  5'd0,  6'h20), 5'd1,  32'h00000007, 1'b1}, // R5 opcode
        '{enc(6'h00, 5'd1, 5'd2, 5'd2,  5'd0,  6'h21), 5'd2,  32'h00000005, 1'b1}, // R5 funct
        '{enc(6'h23, 5'd1, 5'd2, 5'd3,  5'd0,  6'h22), 5'd3,  32'hFFFFFFFF, 1'b1}  // R5 both
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic dbg_load(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        dbg_addr = a; dbg_wdata = d; dbg_we = 1'b1;
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    task automatic peek(input string tag, input logic [4:0] a, input logic [31:0] exp);
        dbg_addr = a;
        #1;
        check(tag, dbg_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7 reset state
        check("R7 flag after reset", {31'd0, illegal_o}, 32'd0);
        peek("R7 r1 after reset", 5'd1, 32'd0);
        peek("R7 r31 after reset", 5'd31, 32'd0);

        dbg_load(5'd1, 32'h7);
        dbg_load(5'd2, 32'h5);
        dbg_load(5'd3, 32'hFFFFFFFF);
        dbg_load(5'd4, 32'h80000000);
        peek("R10 seed r4", 5'd4, 32'h80000000);
        // R4: debug write to register 0 discarded
        dbg_load(5'd0, 32'hABCD1234);
        peek("R4 debug write r0", 5'd0, 32'd0);

        // R1 table walk, back-to-back valid words
        instr_valid = 1'b1;
        instr_word  = VEC[0].word;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            dbg_addr = VEC[i].chk;
            #1;
            check($sformatf("R1 vec%0d reg", i), dbg_rdata, VEC[i].exp);
            check($sformatf("R5 vec%0d flag", i), {31'd0, illegal_o}, {31'd0, VEC[i].ill});
            if (i < NV - 1) instr_word = VEC[i + 1].word;
            else            instr_valid = 1'b0;
        end
        @(negedge clk);
        check("R5 flag one cycle", {31'd0, illegal_o}, 32'd0);

        // R6: invalid cycle with a word that would be legal and would be illegal
        instr_word = enc(6'h00, 5'd1, 5'd2, 5'd13, 5'd0, 6'h20);
        @(negedge clk);
        instr_word = enc(6'h3F, 5'd1, 5'd2, 5'd13, 5'd0, 6'h3F);
        @(negedge clk);
        check("R6 idle flag", {31'd0, illegal_o}, 32'd0);
        peek("R6 idle no write", 5'd13, 32'd0);

        // R8: old value visible before the edge, new one after
        dbg_addr = 5'd5;
        instr_valid = 1'b1;
        instr_word = enc(6'h00, 5'd1, 5'd1, 5'd5, 5'd0, 6'h20);
        #1;
        check("R8 pre-edge read", dbg_rdata, 32'h18);
        @(negedge clk);
        instr_valid = 1'b0;
        peek("R8 post-edge read", 5'd5, 32'h0E);

        // R10: same register, instruction wins
        dbg_addr = 5'd13; dbg_wdata = 32'hDEAD0000; dbg_we = 1'b1;
        instr_valid = 1'b1;
        instr_word = enc(6'h00, 5'd1, 5'd2, 5'd13, 5'd0, 6'h20);
        @(negedge clk);
        dbg_we = 1'b0; instr_valid = 1'b0;
        peek("R10 clash instr wins", 5'd13, 32'h0C);

        // R10: different registers both land; R9 read of r31 boundary
        dbg_addr = 5'd14; dbg_wdata = 32'h00000055; dbg_we = 1'b1;
        instr_valid = 1'b1;
        instr_word = enc(6'h00, 5'd1, 5'd1, 5'd31, 5'd0, 6'h22);
        @(negedge clk);
        dbg_we = 1'b0; instr_valid = 1'b0;
        peek("R10 debug lands", 5'd14, 32'h55);
        peek("R9 r31 via debug", 5'd31, 32'd0);
        instr_valid = 1'b1;
        instr_word = enc(6'h00, 5'd3, 5'd0, 5'd31, 5'd0, 6'h20);
        @(negedge clk);
        instr_valid = 1'b0;
        peek("R9 r31 written", 5'd31, 32'hFFFFFFFF);

        // R7: reset mid-run clears registers and flag
        instr_valid = 1'b1;
        instr_word = enc(6'h01, 5'd0, 5'd0, 5'd0, 5'd0, 6'h00);
        @(negedge clk);
        instr_valid = 1'b0;
        check("R5 flag before reset", {31'd0, illegal_o}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R7 flag cleared", {31'd0, illegal_o}, 32'd0);
        peek("R7 r31 cleared", 5'd31, 32'd0);
        peek("R7 r1 cleared", 5'd1, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule